// File: doc/BRIEF.md
# UART Transmit Interrupt Generator

This block sits between the register interface of a UART and its transmit serializer. It owns the one-character transmit holding register and keeps track of whether the serializer still holds a character. It hands a buffered character to the serializer one cycle after the serializer reports that its last bit has left the line.

From the two occupancy flags it produces two transmit status conditions. The first, "holding empty", means software may write another character. The second, "transmit done", means the holding register is empty and the shifter is idle, so the line has fully drained. Each condition has its own enable bit. The masked conditions drive a single interrupt line and a small identification code.

Writing a character into the holding register removes both conditions, because it fills the holding register. Software therefore acknowledges either transmit interrupt by supplying the next character. Disabling a source only masks the interrupt. The status outputs keep their values.

Top module: `uart_txi`

## Requirements
- R1: While reset is applied and after it is released, holding empty and transmit done both read 1, the interrupt output and the identification code read 0, and no load is issued.
- R2: A holding register write makes both holding empty and transmit done read 0 from the next cycle, which also clears the interrupt output and the identification code for these sources.
- R3: If the holding register is full when the serializer pulses `shift_done_i`, then `tx_load_o` is high in the following cycle and `tx_data_o` carries the buffered character. After that cycle the holding register is empty and the shifter counts as busy.
- R4: A write into an empty holding register while the shifter is idle raises `tx_load_o` in the cycle after the write, carrying the written character.
- R5: Transmit done reads 1 only when the holding register is empty and the shifter is idle. It becomes 1 in the cycle after the `shift_done_i` pulse that ends the last character.
- R6: An interrupt-enable write takes `ier_wdata_i` bit 0 as the holding-empty enable and bit 1 as the transmit-done enable. `irq_o` is high exactly when an enabled condition is present.
- R7: Clearing an enable bit masks the interrupt only: the status outputs keep their values.
- R8: `irq_id_o` reads 1 for holding empty, 2 for transmit done and 0 for none. When both sources are pending, holding empty takes priority.
- R9: A write to a full holding register replaces the buffered character. A write in the same cycle as a load keeps the new character buffered while the old one goes to the shifter.
- R10: A `shift_done_i` pulse while the shifter is idle has no effect on status or load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| thr_wr_i | input | 1 | Holding register write strobe |
| thr_wdata_i | input | DW | Character to buffer |
| shift_done_i | input | 1 | Serializer finished its last bit (one-cycle pulse) |
| ier_wr_i | input | 1 | Interrupt-enable register write strobe |
| ier_wdata_i | input | 2 | Enables: bit 0 holding empty, bit 1 transmit done |
| tx_load_o | output | 1 | Transfer a character into the serializer this cycle |
| tx_data_o | output | DW | Character being transferred |
| irq_o | output | 1 | Transmit interrupt request |
| irq_id_o | output | 2 | Highest-priority pending source (0 none, 1 empty, 2 done) |
| stat_empty_o | output | 1 | Holding register empty status |
| stat_done_o | output | 1 | Transmission complete status |

## Verification
Two corner cases get the most attention: a write in the same cycle as a load, and a write to an already full holding register. A design that drops the new character, or sends the newest character early, shows the wrong data on `tx_load_o`. The bench sets both enable bits together and expects code 1. A wrong priority encoder reports 2 instead. A design that latches "done" as soon as the shifter idles, without checking the holding register, reports completion while a character is still pending. A design that wires the enables into the status shows the status dropping when an enable is cleared.

// File: rtl/uart_txi_pkg.sv
package uart_txi_pkg;
  // Interrupt source indices; a lower index has higher priority.
  localparam int unsigned SRC_EMPTY = 0;
  localparam int unsigned SRC_DONE  = 1;
  localparam int unsigned NSRC      = 2;
  // Identification code width: 0 means none, i+1 means source i.
  localparam int unsigned IDW       = $clog2(NSRC + 1);
endpackage

// File: rtl/uart_txi_hold.sv
module uart_txi_hold #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          shift_done_i,
  output logic          load_o,
  output logic [DW-1:0] ldata_o,
  output logic          full_o,
  output logic          busy_o
);
  logic          full_q, full_d;
  logic          busy_q, busy_d;
  logic [DW-1:0] data_q;

  // A load fires while a character waits and the shifter is free.
  assign load_o  = full_q & ~busy_q;
  assign ldata_o = data_q;
  assign full_o  = full_q;
  assign busy_o  = busy_q;

  always_comb begin
    full_d = full_q;
    busy_d = busy_q;
    if (load_o) begin
      full_d = 1'b0;
      busy_d = 1'b1;
    end else if (shift_done_i) begin
      busy_d = 1'b0;
    end
    if (wr_i) begin
      full_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0;
      busy_q <= 1'b0;
    end else begin
      full_q <= full_d;
      busy_q <= busy_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q <= '0;
    end else if (wr_i) begin
      data_q <= wdata_i;
    end
  end

  AST_WR_FILLS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> full_q); // R2

  AST_LOAD_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_done_i && busy_q && full_q) |=> load_o); // R3

  AST_LOAD_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    (load_o && !wr_i) |=> (!full_q && busy_q)); // R3

  AST_IDLE_PULSE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_done_i && !busy_q && !full_q && !wr_i) |=> (!busy_q && !full_q)); // R10
endmodule

// File: rtl/uart_txi_src.sv
module uart_txi_src
  import uart_txi_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            full_i,
  input  logic            busy_i,
  input  logic            ier_wr_i,
  input  logic [NSRC-1:0] ier_wdata_i,
  output logic [NSRC-1:0] stat_o,
  output logic [NSRC-1:0] pend_o
);
  logic [NSRC-1:0] en_q, en_d;

  always_comb begin
    stat_o            = '0;
    stat_o[SRC_EMPTY] = ~full_i;
    stat_o[SRC_DONE]  = ~full_i & ~busy_i;
  end

  always_comb begin
    en_d = en_q;
    if (ier_wr_i) begin
      en_d = ier_wdata_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
    end else begin
      en_q <= en_d;
    end
  end

  assign pend_o = stat_o & en_q;

  AST_ENABLE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ier_wr_i |=> (en_q == $past(ier_wdata_i))); // R6
endmodule

// File: rtl/uart_txi_ident.sv
module uart_txi_ident
  import uart_txi_pkg::*;
(
  input  logic [NSRC-1:0] pend_i,
  output logic            irq_o,
  output logic [IDW-1:0]  id_o
);
  // Scan from the lowest priority up so the highest priority wins.
  always_comb begin
    id_o = '0;
    for (int i = NSRC - 1; i >= 0; i--) begin
      if (pend_i[i]) begin
        id_o = IDW'(i + 1);
      end
    end
  end

  assign irq_o = |pend_i;
endmodule

// File: rtl/uart_txi.sv
module uart_txi
  import uart_txi_pkg::*;
#(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          thr_wr_i,
  input  logic [DW-1:0] thr_wdata_i,
  input  logic          shift_done_i,
  input  logic          ier_wr_i,
  input  logic [1:0]    ier_wdata_i,
  output logic          tx_load_o,
  output logic [DW-1:0] tx_data_o,
  output logic          irq_o,
  output logic [1:0]    irq_id_o,
  output logic          stat_empty_o,
  output logic          stat_done_o
);
  logic [1:0]      rst_sync_q;
  logic            rst_int_n;
  logic            full, busy;
  logic [NSRC-1:0] stat, pend;
  logic [IDW-1:0]  id;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_int_n = rst_sync_q[1];

  uart_txi_hold #(.DW(DW)) u_hold (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .wr_i         (thr_wr_i),
    .wdata_i      (thr_wdata_i),
    .shift_done_i (shift_done_i),
    .load_o       (tx_load_o),
    .ldata_o      (tx_data_o),
    .full_o       (full),
    .busy_o       (busy)
  );

  uart_txi_src u_src (
    .clk         (clk),
    .rst_n       (rst_int_n),
    .full_i      (full),
    .busy_i      (busy),
    .ier_wr_i    (ier_wr_i),
    .ier_wdata_i (ier_wdata_i),
    .stat_o      (stat),
    .pend_o      (pend)
  );

  uart_txi_ident u_ident (
    .pend_i (pend),
    .irq_o  (irq_o),
    .id_o   (id)
  );

  assign irq_id_o     = 2'(id);
  assign stat_empty_o = stat[SRC_EMPTY];
  assign stat_done_o  = stat[SRC_DONE];

  AST_DONE_NEEDS_EMPTY: assert property (@(posedge clk) disable iff (!rst_int_n)
    stat_done_o |-> stat_empty_o); // R5

  AST_WR_CLEARS_STATUS: assert property (@(posedge clk) disable iff (!rst_int_n)
    thr_wr_i |=> (!stat_empty_o && !stat_done_o && !irq_o)); // R2

  AST_IRQ_NEEDS_STATUS: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_o |-> (stat_empty_o || stat_done_o)); // R6

  AST_ID_MATCHES_IRQ: assert property (@(posedge clk) disable iff (!rst_int_n)
    irq_o == (irq_id_o != 2'd0)); // R8
endmodule

// File: tb/test_uart_txi.sv
module test_uart_txi;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       thr_wr_i;
  logic [7:0] thr_wdata_i;
  logic       shift_done_i;
  logic       ier_wr_i;
  logic [1:0] ier_wdata_i;
  logic       tx_load_o;
  logic [7:0] tx_data_o;
  logic       irq_o;
  logic [1:0] irq_id_o;
  logic       stat_empty_o;
  logic       stat_done_o;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  uart_txi #(.DW(8)) i_uart_txi (
    .clk          (clk),
    .rst_n        (rst_n),
    .thr_wr_i     (thr_wr_i),
    .thr_wdata_i  (thr_wdata_i),
    .shift_done_i (shift_done_i),
    .ier_wr_i     (ier_wr_i),
    .ier_wdata_i  (ier_wdata_i),
    .tx_load_o    (tx_load_o),
    .tx_data_o    (tx_data_o),
    .irq_o        (irq_o),
    .irq_id_o     (irq_id_o),
    .stat_empty_o (stat_empty_o),
    .stat_done_o  (stat_done_o)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic check(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] d);
    thr_wr_i = 1'b1; thr_wdata_i = d;
    tick();
    thr_wr_i = 1'b0;
  endtask

  task automatic pulse_done();
    shift_done_i = 1'b1;
    tick();
    shift_done_i = 1'b0;
  endtask

  task automatic set_ier(logic [1:0] v);
    ier_wr_i = 1'b1; ier_wdata_i = v;
    tick();
    ier_wr_i = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) tick();
    check("R1 empty in reset", stat_empty_o, 1);
    check("R1 done in reset", stat_done_o, 1);
    rst_n = 1'b1;
    repeat (3) tick();
    check("R1 empty", stat_empty_o, 1);
    check("R1 done", stat_done_o, 1);
    check("R1 irq", irq_o, 0);
    check("R1 id", irq_id_o, 0);
    check("R1 load", tx_load_o, 0);
  endtask

  task automatic t_basic();
    wr(8'hA5);
    check("R4 load after write", tx_load_o, 1);
    check("R4 load data", tx_data_o, 'hA5);
    check("R2 empty cleared", stat_empty_o, 0);
    tick();
    check("R3 load one cycle", tx_load_o, 0);
    check("R5 empty while shifting", stat_empty_o, 1);
    check("R5 done while shifting", stat_done_o, 0);
    wr(8'h3C);
    check("R2 empty after write", stat_empty_o, 0);
    check("R2 no load while busy", tx_load_o, 0);
    pulse_done();
    check("R3 load after shift done", tx_load_o, 1);
    check("R3 load data", tx_data_o, 'h3C);
    tick();
    check("R3 empty after load", stat_empty_o, 1);
    check("R5 not done yet", stat_done_o, 0);
    pulse_done();
    check("R5 done after last shift", stat_done_o, 1);
  endtask

  task automatic t_enables();
    set_ier(2'b01);
    check("R6 irq empty enabled", irq_o, 1);
    check("R8 id empty", irq_id_o, 1);
    set_ier(2'b10);
    check("R8 id done", irq_id_o, 2);
    set_ier(2'b00);
    check("R7 irq masked", irq_o, 0);
    check("R7 empty kept", stat_empty_o, 1);
    check("R7 done kept", stat_done_o, 1);
    set_ier(2'b11);
    check("R8 priority empty", irq_id_o, 1);
    wr(8'h77);
    check("R2 irq cleared", irq_o, 0);
    check("R2 id cleared", irq_id_o, 0);
    tick();
    check("R6 irq after load", irq_o, 1);
    check("R8 id after load", irq_id_o, 1);
    check("R5 done while shifting", stat_done_o, 0);
    pulse_done();
    check("R5 done", stat_done_o, 1);
    check("R8 id both", irq_id_o, 1);
    set_ier(2'b00);
  endtask

  task automatic t_overwrite();
    wr(8'h11);
    tick();
    wr(8'h22);
    wr(8'h33);
    pulse_done();
    check("R9 overwrite load", tx_load_o, 1);
    check("R9 overwrite data", tx_data_o, 'h33);
    tick();
    wr(8'h44);
    pulse_done();
    check("R9 load before collide", tx_load_o, 1);
    check("R9 old data", tx_data_o, 'h44);
    wr(8'h55);
    check("R9 new kept full", stat_empty_o, 0);
    check("R9 no load busy", tx_load_o, 0);
    pulse_done();
    check("R9 new data loaded", tx_load_o, 1);
    check("R9 new data", tx_data_o, 'h55);
    tick();
    pulse_done();
    check("R5 drained", stat_done_o, 1);
  endtask

  task automatic t_spurious();
    pulse_done();
    check("R10 done unchanged", stat_done_o, 1);
    check("R10 empty unchanged", stat_empty_o, 1);
    check("R10 no load", tx_load_o, 0);
    tick();
    check("R10 still no load", tx_load_o, 0);
  endtask

  initial begin
    repeat (10000) @(posedge clk);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    thr_wr_i = 1'b0;
    thr_wdata_i = '0;
    shift_done_i = 1'b0;
    ier_wr_i = 1'b0;
    ier_wdata_i = '0;
    t_reset();
    t_basic();
    t_enables();
    t_overwrite();
    t_spurious();
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule